// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits in front of a synchronous pipelined static RAM and supplies the word address for each beat of a four-beat burst. On a clock edge where a burst is started, it captures the external address. After that it holds the upper address bits fixed and produces the two lowest bits from a two-bit beat counter. The counter steps once on each clock edge where the advance strobe is active. When no start strobe and no advance strobe are active, the address stays where it is, so a burst can be suspended and then resumed.

Two independent start strobes exist, one driven by a processor and one by a cache controller. Either of them loads the address. A start strobe always takes priority over the advance strobe. A level input chooses how the low bits are ordered. Linear order adds the beat count to the starting low bits, modulo four. Interleaved order XORs the beat count into the starting low bits. The input is sampled on each clock edge, and the sampled value controls the address shown in the following cycle. Every input is captured on the rising clock edge, and the output is derived only from registered state.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `addr_out` equal to 0, and the beat count is cleared.
- R2: When `start_cpu_n` is low at a rising edge, `addr_out` in the next cycle equals the `addr_in` sampled at that edge. This holds whatever the level of `adv_n`.
- R3: When `start_ctl_n` is low at a rising edge, `addr_out` in the next cycle equals the `addr_in` sampled at that edge, exactly as in R2. When both start strobes are low together, the address is loaded once.
- R4: With `order_sel` = 0 (linear), each edge where `adv_n` is low and both start strobes are high makes the two lowest bits of `addr_out` equal to the previous two lowest bits plus 1, modulo 4.
- R5: With `order_sel` = 1 (interleaved), beat k of a burst has low bits equal to the starting low bits XOR k, for k = 0, 1, 2, 3. Starting at 1, for example, gives 1, 0, 3, 2.
- R6: Bits `ADDR_W-1` down to 2 of `addr_out` change only at an edge where a start strobe loads the address. The fifth beat returns to the starting low bits and does not carry into the upper bits.
- R7: At an edge where `start_cpu_n`, `start_ctl_n` and `adv_n` are all high and `order_sel` is unchanged, `addr_out` holds its value.
- R8: When a start strobe and `adv_n` are low at the same edge, the new start address appears with a beat count of 0.
- R9: `order_sel` is sampled on every edge. The low bits shown in the next cycle are computed from the starting low bits and the current beat count in the newly sampled order, even in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External word address |
| start_cpu_n | input | 1 | Processor-side burst start, active low |
| start_ctl_n | input | 1 | Cache-controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 0 selects linear, 1 selects interleaved (tie high when unused) |
| addr_out | output | ADDR_W | Current internal word address |

## Verification
The bound checker checks the following on every cycle:
- the load of either start strobe, including when advance is active at the same edge;
- that the upper bits are frozen between loads;
- that the address holds when the block is idle;
- the plus-one step in linear order;
- the flip of bit 0 on every interleaved step.

Some behaviours are visible only through the bench's scenarios, because they depend on the whole history of the burst. These are the complete interleaved sequence from each starting value, the wrap back to the start on the fifth beat, the reset value, and a change of order in the middle of a burst. The bench sweeps every starting low value, both strobes, both orders and several upper-bit patterns.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic step;
    } seq_ctl_t;

    function automatic beat_t beat_offset(beat_t start, beat_t cnt, order_e ord);
        beat_t res;
        if (ord == ORDER_INTERLEAVE)
            res = start ^ cnt;
        else
            res = beat_t'(start + cnt);
        return res;
    endfunction

endpackage

// File: rtl/burst_ctl_decode.sv
module burst_ctl_decode
    import burst_seq_pkg::*;
(
    input  logic     start_cpu_n,
    input  logic     start_ctl_n,
    input  logic     adv_n,
    output seq_ctl_t ctl
);
    always_comb begin
        ctl.load = ~start_cpu_n | ~start_ctl_n;
        // a start strobe overrides any advance in the same cycle
        ctl.step = ~adv_n & ~ctl.load;
    end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q
);
    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (load)
            base_q <= addr_in;
    end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
    import burst_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_ctl_t ctl,
    output beat_t    cnt_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (ctl.load)
            cnt_q <= '0;
        else if (ctl.step)
            cnt_q <= beat_t'(cnt_q + 1'b1);
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              start_cpu_n,
    input  logic              start_ctl_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UP_W = ADDR_W - BEAT_W;

    seq_ctl_t          ctl;
    logic [ADDR_W-1:0] base_q;
    beat_t             cnt_q;
    order_e            order_q;
    logic [UP_W-1:0]   upper;
    beat_t             low;

    burst_ctl_decode u_dec (
        .start_cpu_n (start_cpu_n),
        .start_ctl_n (start_ctl_n),
        .adv_n       (adv_n),
        .ctl         (ctl)
    );

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.load),
        .addr_in (addr_in),
        .base_q  (base_q)
    );

    burst_beat_cnt u_cnt (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .cnt_q (cnt_q)
    );

    // order level is registered like every other input; reset picks the tie-high default
    always_ff @(posedge clk) begin
        if (rst)
            order_q <= ORDER_INTERLEAVE;
        else
            order_q <= order_e'(order_sel);
    end

    always_comb begin
        upper    = base_q[ADDR_W-1:BEAT_W];
        low      = beat_offset(base_q[BEAT_W-1:0], cnt_q, order_q);
        addr_out = {upper, low};
    end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              start_cpu_n,
    input logic              start_ctl_n,
    input logic              adv_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_out
);
    // R2 R3 R8
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_cpu_n || !start_ctl_n) |=> (addr_out == $past(addr_in)));

    // R6
    upper_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (start_cpu_n && start_ctl_n) |=>
            (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && start_cpu_n && start_ctl_n && adv_n && order_sel == $past(order_sel))
            |=> $stable(addr_out));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && start_cpu_n && start_ctl_n && !adv_n && !order_sel && !$past(order_sel))
            |=> (addr_out[BEAT_W-1:0] == beat_t'($past(addr_out[BEAT_W-1:0]) + 2'd1)));

    // R5
    interleave_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && start_cpu_n && start_ctl_n && !adv_n && order_sel && $past(order_sel))
            |=> (addr_out[0] != $past(addr_out[0])));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .addr_in     (addr_in),
    .start_cpu_n (start_cpu_n),
    .start_ctl_n (start_ctl_n),
    .adv_n       (adv_n),
    .order_sel   (order_sel),
    .addr_out    (addr_out)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
    localparam int CLK_P  = 10;
    localparam int AW     = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_in;
    logic          start_cpu_n;
    logic          start_ctl_n;
    logic          adv_n;
    logic          order_sel;
    logic [AW-1:0] addr_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // reference state computed from the requirements
    logic [AW-1:0] m_base;
    int            m_cnt;
    logic          m_ord;

    always #(CLK_P/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .addr_in     (addr_in),
        .start_cpu_n (start_cpu_n),
        .start_ctl_n (start_ctl_n),
        .adv_n       (adv_n),
        .order_sel   (order_sel),
        .addr_out    (addr_out)
    );

    function automatic logic [AW-1:0] expect_addr();
        int s = int'(m_base[1:0]);
        int lo = m_ord ? (s ^ m_cnt) : ((s + m_cnt) % 4);
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic cyc(input logic r, input logic cpu_n, input logic ctl_n,
                       input logic a_n, input logic ord, input logic [AW-1:0] a,
                       input string req);
        logic [AW-1:0] exp;
        @(negedge clk);
        rst = r; start_cpu_n = cpu_n; start_ctl_n = ctl_n;
        adv_n = a_n; order_sel = ord; addr_in = a;
        @(posedge clk);
        if (r) begin
            m_base = '0; m_cnt = 0; m_ord = 1'b1;
        end else begin
            if (!cpu_n || !ctl_n) begin
                m_base = a; m_cnt = 0;
            end else if (!a_n) begin
                m_cnt = (m_cnt + 1) % 4;
            end
            m_ord = ord;
        end
        #1;
        exp = expect_addr();
        checks++;
        if (addr_out !== exp) begin
            failures++;
            $display("FAIL %s: addr_out=%0h expected=%0h", req, addr_out, exp);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] ups [3] = '{6'h00, 6'h14, 6'h3c};
        rst = 1'b1; start_cpu_n = 1'b1; start_ctl_n = 1'b1;
        adv_n = 1'b1; order_sel = 1'b0; addr_in = '0;
        // R1 reset state
        cyc(1, 1, 1, 1, 0, 6'h2b, "R1");
        cyc(1, 0, 1, 0, 0, 6'h2b, "R1");

        // R2 R3 R4 R5 R6: sweep order, strobe, start low bits, upper bits
        for (int ord = 0; ord < 2; ord++)
            for (int sel = 0; sel < 2; sel++)
                for (int u = 0; u < 3; u++)
                    for (int s = 0; s < 4; s++) begin
                        logic [AW-1:0] a = ups[u] | AW'(s);
                        cyc(0, logic'(sel != 0), logic'(sel == 0), 1, logic'(ord), a,
                            sel == 0 ? "R2" : "R3");
                        for (int k = 0; k < 5; k++)
                            cyc(0, 1, 1, 0, logic'(ord), ~a,
                                ord != 0 ? "R5 R6" : "R4 R6");
                    end

        // R3 both strobes together
        cyc(0, 0, 0, 1, 1, 6'h29, "R3");
        // R7 suspend and resume
        cyc(0, 1, 1, 0, 1, 6'h00, "R5");
        cyc(0, 1, 1, 1, 1, 6'h3f, "R7");
        cyc(0, 1, 1, 1, 1, 6'h15, "R7");
        cyc(0, 1, 1, 0, 1, 6'h00, "R5");
        // R8 start wins over advance, from mid-burst
        cyc(0, 0, 1, 0, 0, 6'h1a, "R8");
        cyc(0, 1, 1, 0, 0, 6'h00, "R4");
        cyc(0, 1, 0, 0, 0, 6'h33, "R8");
        cyc(0, 1, 1, 0, 0, 6'h00, "R4");
        // R9 order change mid-burst
        cyc(0, 1, 1, 0, 0, 6'h00, "R4");
        cyc(0, 1, 1, 1, 1, 6'h00, "R9");
        cyc(0, 1, 1, 0, 1, 6'h00, "R9");
        cyc(0, 1, 1, 1, 0, 6'h00, "R9");
        // R1 reset mid-burst
        cyc(1, 1, 1, 0, 0, 6'h00, "R1");
        cyc(0, 1, 1, 1, 1, 6'h00, "R1 R7");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule